// File: doc/BRIEF.md
# Bfloat16 Adder-Subtractor

This block adds or subtracts two 16-bit brain-float operands and returns a result of the same format after a fixed two-cycle latency. A bit on each request selects subtraction. The unit flips the sign of the second operand and then takes the addition path, so both operations share one datapath. A new request can be accepted on every clock cycle, and results come out in request order.

The first stage works out the special cases: NaN, infinity, zero and a very large exponent gap. For ordinary operands it aligns the smaller operand and combines the significands. The second stage then normalizes the raw sum or difference and packs the output word. Bits shifted out during alignment and normalization are dropped, with no rounding. A result whose exponent would not fit below the all-ones code becomes a signed infinity. A difference whose exponent would reach zero or below becomes positive zero.

Top module: `bf16_addsub`

## Requirements
- R1: A request accepted with `inValid` high at one rising edge sets `outValid` high after exactly the second following rising edge, and `result` holds that request's value. `outValid` is low when no request was accepted two edges earlier, and `result` changes only when `outValid` rises with it. Reset clears `outValid` and `result` to 0.
- R2: With `subtract` high, the unit uses operand b with bit 15 inverted (the effective b), so a − b gives the same word as a + (−b).
- R3: A word with exponent bits 14:7 all ones and a nonzero mantissa in bits 6:0 is a NaN. A NaN in a is returned as a, unchanged. A NaN in b, with a not NaN, is returned as the effective b.
- R4: Two infinities (exponent all ones, mantissa 0) whose effective signs differ give the quiet NaN 0x7FC0. In every other case an infinite operand (a checked first) is the result.
- R5: An operand whose bits 14:0 are all 0 counts as zero. If a is zero the result is the effective b. Otherwise, if b is zero, the result is a.
- R6: When the exponents differ by more than 8, the result is the operand with the larger exponent (the effective b if that is b).
- R7: Otherwise a nonzero exponent adds a hidden 1 at significand bit 7. The significand with the smaller exponent is shifted right by the exponent difference, with bits truncated, and the larger exponent is kept.
- R8: With equal effective signs the significands are added. A carry into bit 8 shifts the sum right by one and raises the exponent by one.
- R9: If that raised exponent reaches 255, the result is sign | 0x7F80.
- R10: With differing signs the smaller aligned significand is subtracted from the larger, and the result takes the sign of the larger (a on a tie). A zero difference gives 0x0000.
- R11: A nonzero difference is normalized in one step by its leading-zero count, and the exponent is lowered by that count. If the lowered exponent is 0 or less, the result is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| opA | input | 16 | Operand a |
| opB | input | 16 | Operand b |
| subtract | input | 1 | 1 selects a − b |
| outValid | output | 1 | Result strobe, two cycles after the request |
| result | output | 16 | Result word |

## Verification
The case hardest to reach from the ports is a cancelling subtraction whose leading-zero count brings the exponent to exactly zero, or to one just above it. This needs operands with a small exponent whose significands differ only in their last bit. The bench drives such pairs directly: one at exponent 7 (expected to flush to zero), one at exponent 8 (expected to survive as exponent 1) and one at exponent 1 (expected to flush). This pins down where the underflow boundary lies. The bench also sends three requests back to back to confirm that both pipeline stages carry independent data in the same cycle.

// File: rtl/bf16_pkg.sv
package bf16_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 7;
  localparam int WORD_W = 1 + EXP_W + MAN_W;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAlign;
    logic loadPack;
  } stepCtl_t;
endpackage

// File: rtl/lead_zero_count.sv
module lead_zero_count #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [CW-1:0] count
);
  // scan upward; the highest set bit wins
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (value[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bf16_addsub_ctrl.sv
module bf16_addsub_ctrl
  import bf16_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output stepCtl_t ctl,
  output logic     outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    ctl.loadAlign = inValid;
    ctl.loadPack  = stage1Valid;
  end

  assign outValid = stage2Valid;
endmodule

// File: rtl/bf16_addsub_datapath.sv
module bf16_addsub_datapath
  import bf16_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  stepCtl_t            ctl,
  input  logic [EW+MW:0]      opA,
  input  logic [EW+MW:0]      opB,
  input  logic                subtract,
  output logic [EW+MW:0]      result
);
  localparam int WW      = 1 + EW + MW;
  localparam int SW      = MW + 1;
  localparam int LZW     = $clog2(SW + 1);
  localparam int EXP_TOP = (1 << EW) - 1;
  localparam logic [WW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  // ---------------- stage 1: classify and align ----------------
  logic [WW-1:0] effB;
  logic          signA, signB;
  logic [EW-1:0] expA, expB;
  logic [MW-1:0] manA, manB;
  logic          aTop, bTop, aNan, bNan, aInf, bInf, aZero, bZero;
  logic [SW-1:0] sigA, sigB, alA, alB;
  logic          aBig;
  logic [EW-1:0] gap, bigExp;

  assign effB  = {opB[WW-1] ^ subtract, opB[WW-2:0]};
  assign signA = opA[WW-1];
  assign signB = effB[WW-1];
  assign expA  = opA[WW-2:MW];
  assign expB  = effB[WW-2:MW];
  assign manA  = opA[MW-1:0];
  assign manB  = effB[MW-1:0];

  assign aTop  = &expA;
  assign bTop  = &expB;
  assign aNan  = aTop && (|manA);
  assign bNan  = bTop && (|manB);
  assign aInf  = aTop && !(|manA);
  assign bInf  = bTop && !(|manB);
  assign aZero = (expA == '0) && (manA == '0);
  assign bZero = (expB == '0) && (manB == '0);

  assign sigA   = {|expA, manA};
  assign sigB   = {|expB, manB};
  assign aBig   = (expA >= expB);
  assign gap    = aBig ? (expA - expB) : (expB - expA);
  assign bigExp = aBig ? expA : expB;
  assign alA    = aBig ? sigA : (sigA >> gap);
  assign alB    = aBig ? (sigB >> gap) : sigB;

  logic          nxtSpecial;
  logic [WW-1:0] nxtWord;
  logic          nxtSign;
  logic          nxtDiff;
  logic [SW:0]   nxtMant;

  always_comb begin
    nxtSpecial = 1'b1;
    nxtWord    = opA;
    if (aNan) begin
      nxtWord = opA;
    end else if (aInf) begin
      if (bInf && (signA != signB)) nxtWord = QNAN;
      else if (bNan)                nxtWord = effB;
      else                          nxtWord = opA;
    end else if (bTop) begin
      nxtWord = effB;
    end else if (aZero) begin
      nxtWord = effB;
    end else if (bZero) begin
      nxtWord = opA;
    end else if (gap > EW'(SW)) begin
      nxtWord = aBig ? opA : effB;
    end else begin
      nxtSpecial = 1'b0;
    end
  end

  always_comb begin
    nxtDiff = (signA != signB);
    if (!nxtDiff) begin
      nxtSign = signA;
      nxtMant = {1'b0, alA} + {1'b0, alB};
    end else if (alA >= alB) begin
      nxtSign = signA;
      nxtMant = {1'b0, alA - alB};
    end else begin
      nxtSign = signB;
      nxtMant = {1'b0, alB - alA};
    end
  end

  logic          s1Special;
  logic [WW-1:0] s1Word;
  logic          s1Sign;
  logic          s1Diff;
  logic [EW-1:0] s1Exp;
  logic [SW:0]   s1Mant;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Special <= 1'b0;
      s1Word    <= '0;
      s1Sign    <= 1'b0;
      s1Diff    <= 1'b0;
      s1Exp     <= '0;
      s1Mant    <= '0;
    end else if (ctl.loadAlign) begin
      s1Special <= nxtSpecial;
      s1Word    <= nxtWord;
      s1Sign    <= nxtSign;
      s1Diff    <= nxtDiff;
      s1Exp     <= bigExp;
      s1Mant    <= nxtMant;
    end
  end

  // ---------------- stage 2: normalize and pack ----------------
  logic           carry;
  logic [LZW-1:0] lz;
  logic [EW:0]    expUp;
  logic [EW-1:0]  expDown;
  logic [MW-1:0]  sumMan, normMan;
  logic [WW-1:0]  packWord;

  lead_zero_count #(.W(SW), .CW(LZW)) u_lzc (
    .value (s1Mant[SW-1:0]),
    .count (lz)
  );

  assign carry   = s1Mant[SW];
  assign expUp   = {1'b0, s1Exp} + 1'b1;
  assign expDown = s1Exp - EW'(lz);
  assign sumMan  = carry ? s1Mant[MW:1] : s1Mant[MW-1:0];
  assign normMan = MW'(s1Mant[SW-1:0] << lz);

  always_comb begin
    if (s1Special) begin
      packWord = s1Word;
    end else if (!s1Diff) begin
      if (carry && (expUp >= (EW+1)'(EXP_TOP)))
        packWord = {s1Sign, {EW{1'b1}}, {MW{1'b0}}};
      else if (carry)
        packWord = {s1Sign, expUp[EW-1:0], sumMan};
      else
        packWord = {s1Sign, s1Exp, sumMan};
    end else begin
      if (s1Mant == '0)
        packWord = '0;
      else if ((lz != '0) && (s1Exp <= EW'(lz)))
        packWord = '0;
      else
        packWord = {s1Sign, expDown, normMan};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               result <= '0;
    else if (ctl.loadPack) result <= packWord;
  end
endmodule

// File: rtl/bf16_addsub.sv
module bf16_addsub
  import bf16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subtract,
  output logic              outValid,
  output logic [WORD_W-1:0] result
);
  stepCtl_t ctl;

  bf16_addsub_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  bf16_addsub_datapath #(.EW(EXP_W), .MW(MAN_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .subtract (subtract),
    .result   (result)
  );
endmodule

// File: rtl/bf16_addsub_check.sv
module bf16_addsub_check
  import bf16_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              subtract,
  input logic              outValid,
  input logic [WORD_W-1:0] result
);
  logic aNaN, aInf, bInf, aNormal, bZero, effSignB;
  assign aNaN     = (&opA[14:7]) && (|opA[6:0]);
  assign aInf     = (&opA[14:7]) && !(|opA[6:0]);
  assign bInf     = (&opB[14:7]) && !(|opB[6:0]);
  assign aNormal  = !(&opA[14:7]) && (opA[14:0] != 15'd0);
  assign bZero    = (opB[14:0] == 15'd0);
  assign effSignB = opB[15] ^ subtract;

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##2 outValid);

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##2 !outValid);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(result));

  p_nan_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && aNaN) |-> ##2 (result == $past(opA, 2)));

  p_inf_clash_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && aInf && bInf && (opA[15] != effSignB)) |-> ##2 (result == 16'h7FC0));

  p_zero_b_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && aNormal && bZero) |-> ##2 (result == $past(opA, 2)));
endmodule

bind bf16_addsub bf16_addsub_check chk (.*);

// File: tb/bf16_addsub_test.sv
module bf16_addsub_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        subtract = 1'b0;
  logic        outValid;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bf16_addsub uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .subtract(subtract), .outValid(outValid), .result(result)
  );

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic [15:0] a, input logic [15:0] b,
                       input logic sub, input logic [15:0] exp);
    @(negedge clk);
    opA = a; opB = b; subtract = sub; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkEq({tag, " R1 early"}, {15'd0, outValid}, 16'd0);
    @(negedge clk);
    checkEq({tag, " R1 valid"}, {15'd0, outValid}, 16'd1);
    checkEq(tag, result, exp);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1 reset outValid", {15'd0, outValid}, 16'd0);
    checkEq("R1 reset result", result, 16'h0000);
  endtask

  task automatic testStream();
    // three back-to-back requests (R1, R8, R7)
    @(negedge clk);
    opA = 16'h3F80; opB = 16'h3F80; subtract = 1'b0; inValid = 1'b1;
    @(negedge clk);
    opA = 16'h3FC0; opB = 16'h3FC0;
    @(negedge clk);
    checkEq("R1 stream valid0", {15'd0, outValid}, 16'd1);
    checkEq("R8 stream res0", result, 16'h4000);
    opA = 16'h3F80; opB = 16'h4000;
    @(negedge clk);
    inValid = 1'b0;
    checkEq("R8 stream res1", result, 16'h4040);
    @(negedge clk);
    checkEq("R7 stream res2", result, 16'h4040);
    @(negedge clk);
    checkEq("R1 stream idle", {15'd0, outValid}, 16'd0);
    checkEq("R1 stream hold", result, 16'h4040);
  endtask

  task automatic testSubFlip();
    runOp("R2 2-1",       16'h4000, 16'h3F80, 1'b1, 16'h3F80);
    runOp("R2 2+(-1)",    16'h4000, 16'hBF80, 1'b0, 16'h3F80);
    runOp("R2 1-2",       16'h3F80, 16'h4000, 1'b1, 16'hBF80);
  endtask

  task automatic testNan();
    runOp("R3 a nan",      16'h7FC1, 16'h3F80, 1'b0, 16'h7FC1);
    runOp("R3 a nan b inf",16'h7FC1, 16'hFF80, 1'b0, 16'h7FC1);
    runOp("R3 b nan",      16'h3F80, 16'h7FA0, 1'b0, 16'h7FA0);
    runOp("R3 b nan sub",  16'h3F80, 16'h7FA0, 1'b1, 16'hFFA0);
    runOp("R3 inf b nan",  16'h7F80, 16'h7FC5, 1'b0, 16'h7FC5);
  endtask

  task automatic testInf();
    runOp("R4 +inf + -inf", 16'h7F80, 16'hFF80, 1'b0, 16'h7FC0);
    runOp("R4 inf - inf",   16'h7F80, 16'h7F80, 1'b1, 16'h7FC0);
    runOp("R4 inf + inf",   16'h7F80, 16'h7F80, 1'b0, 16'h7F80);
    runOp("R4 -inf + 1",    16'hFF80, 16'h3F80, 1'b0, 16'hFF80);
    runOp("R4 1 + -inf",    16'h3F80, 16'hFF80, 1'b0, 16'hFF80);
    runOp("R4 1 - inf",     16'h3F80, 16'h7F80, 1'b1, 16'hFF80);
  endtask

  task automatic testZero();
    runOp("R5 0 + 3",   16'h0000, 16'h4040, 1'b0, 16'h4040);
    runOp("R5 3 + -0",  16'h4040, 16'h8000, 1'b0, 16'h4040);
    runOp("R5 0 - 3",   16'h0000, 16'h4040, 1'b1, 16'hC040);
    runOp("R5 -0 + 0",  16'h8000, 16'h0000, 1'b0, 16'h0000);
  endtask

  task automatic testGap();
    runOp("R6 gap9 a",     16'h4400, 16'h3F80, 1'b0, 16'h4400);
    runOp("R6 gap9 b",     16'h3F80, 16'h4400, 1'b0, 16'h4400);
    runOp("R6 gap9 b sub", 16'h3F80, 16'h4400, 1'b1, 16'hC400);
  endtask

  task automatic testAlign();
    runOp("R7 1+2",        16'h3F80, 16'h4000, 1'b0, 16'h4040);
    runOp("R7 truncate",   16'h3F83, 16'h4000, 1'b0, 16'h4041);
    runOp("R7 gap7",       16'h4300, 16'h3F80, 1'b0, 16'h4301);
    runOp("R7 gap8",       16'h4380, 16'h3F80, 1'b0, 16'h4380);
  endtask

  task automatic testCarry();
    runOp("R8 1+1",     16'h3F80, 16'h3F80, 1'b0, 16'h4000);
    runOp("R8 1.5+1.5", 16'h3FC0, 16'h3FC0, 1'b0, 16'h4040);
  endtask

  task automatic testOverflow();
    runOp("R9 +max+max", 16'h7F7F, 16'h7F7F, 1'b0, 16'h7F80);
    runOp("R9 -max+-max",16'hFF7F, 16'hFF7F, 1'b0, 16'hFF80);
  endtask

  task automatic testCancel();
    runOp("R10 1-1",      16'h3F80, 16'h3F80, 1'b1, 16'h0000);
    runOp("R10 1+(-1)",   16'h3F80, 16'hBF80, 1'b0, 16'h0000);
    runOp("R10 -2+1",     16'hC000, 16'h3F80, 1'b0, 16'hBF80);
  endtask

  task automatic testNormalize();
    runOp("R11 lz7",      16'h3F81, 16'h3F80, 1'b1, 16'h3C00);
    runOp("R11 exp to 0", 16'h0381, 16'h0380, 1'b1, 16'h0000);
    runOp("R11 exp to 1", 16'h0401, 16'h0400, 1'b1, 16'h0080);
    runOp("R11 exp1 lz7", 16'h0081, 16'h0080, 1'b1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rst = 1'b0;
    testStream();
    testSubFlip();
    testNan();
    testInf();
    testZero();
    testGap();
    testAlign();
    testCarry();
    testOverflow();
    testCancel();
    testNormalize();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule